// File: doc/BRIEF.md
# Fragmented Mailbox Message Receiver

This block collects one inbound message from a word-wide mailbox queue. The message may arrive in several fragments, and each fragment opens with a header word. The block pops words through the mailbox read window and rebuilds the byte message. It hands the bytes out on a valid/ready stream, least significant byte of each word first. A fragment whose complete flag is set ends the message. The block then reports the total byte count, or an error code when the message was abandoned.

A receive operation starts with a one-cycle `start_i` pulse. That pulse carries the space available downstream (`max_len_i`) and a wait limit in cycles (`timeout_i`). While running, the block clears the interrupt status once. It requests more data from the sender when a fragment is not final and the queue has run dry. It aborts when a fragment does not fit, when the sender drops its ready line, or when a wait for queue words takes too long. The meaning of the message bytes is left to the consumer.

Top module: `rx_reasm`

## Requirements
- R1: After start, the block waits until at least one word is queued (`fill_cnt_i` > 0), then pops the head word as a header. The fragment length in bytes is header bits [24:16], and bit 31 is the complete flag. The other header bits are ignored.
- R2: If a fragment length is larger than the space still left out of `max_len_i`, the message ends with `err_o` = 1 (size). No payload word of that fragment is popped.
- R3: Before it pops any payload word, the block waits until at least ceil(length/4) words are queued. It never pops while `fill_cnt_i` is 0.
- R4: Payload bytes leave on the stream in arrival order, bits [7:0] of a word first. Exactly `length` bytes leave per fragment, and of a final partial word only the low (length mod 4) bytes are kept. Each payload word is popped on the handshake of its last kept byte.
- R5: Once all whole payload words of a fragment have been popped, `peer_rdy_i` is sampled. If it is low, the message ends with `err_o` = 2 (peer), and any partial tail word stays unpopped.
- R6: When a fragment without the complete flag has been consumed and the queue is empty, `irq_gen_o` pulses for one cycle. No pulse occurs if more words are already queued.
- R7: A message succeeds (`ok_o` = 1, `err_o` = 0) only after a fragment with the complete flag has been consumed. `rx_len_o` is then the sum of all fragment lengths.
- R8: A zero-length fragment is accepted and sets `zero_warn_o` for that message.
- R9: `irq_clr_o` pulses for exactly one cycle, in the cycle a receive operation is accepted.
- R10: A wait for queued words (header or payload) that lasts more than `timeout_i` cycles ends the message with `err_o` = 3 (timeout).
- R11: While `byte_valid_o` is high and `byte_ready_i` is low, `byte_data_o` and `byte_valid_o` hold.
- R12: `done_o` is a one-cycle pulse. The results hold until the next accepted start, and a start while busy is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Begin a receive operation (ignored while busy) |
| max_len_i | input | BUF_W | Output space in bytes |
| timeout_i | input | TO_W | Wait limit in cycles |
| fill_cnt_i | input | CNT_W | Number of queued mailbox words |
| slot_data_i | input | 32 | Head word of the mailbox queue |
| peer_rdy_i | input | 1 | Sender ready |
| slot_pop_o | output | 1 | Pop the head word |
| irq_clr_o | output | 1 | Clear interrupt status pulse |
| irq_gen_o | output | 1 | Request-more-data pulse to the sender |
| byte_data_o | output | 8 | Output byte |
| byte_valid_o | output | 1 | Output byte valid |
| byte_ready_i | input | 1 | Downstream accepts byte |
| busy_o | output | 1 | Operation in progress |
| done_o | output | 1 | Operation finished pulse |
| ok_o | output | 1 | Last operation succeeded |
| err_o | output | 2 | 0 none, 1 size, 2 peer, 3 timeout |
| rx_len_o | output | BUF_W | Total bytes received |
| zero_warn_o | output | 1 | A zero-length fragment was seen |

## Verification
The stimulus covers three kinds of message. The first is a single fragment with a partial tail word under random backpressure, which shows byte order and tail trimming. The second is three fragments queued in advance, which must not raise a data request. The third is a non-final fragment followed by an empty queue, where the second fragment is pushed only after `irq_gen_o`; this separates the request path from plain draining. Further runs cover each abort cause: a length one byte too large, and one exactly equal to the space left; space exhausted by an earlier fragment; the sender dropping ready with a tail word pending; and a payload that never fully arrives. Each abort is distinguished by its error code and by how many words remain queued.

// File: rtl/rx_reasm_pkg.sv
package rx_reasm_pkg;
  localparam int SLOT_W    = 32;
  localparam int SLOT_B    = SLOT_W / 8;
  localparam int HLEN_W    = 9;
  localparam int HLEN_LSB  = 16;
  localparam int HDONE_BIT = 31;

  typedef enum logic [2:0] {
    ST_IDLE, ST_HDR, ST_BODY, ST_STREAM, ST_CHECK, ST_NEXT, ST_DONE
  } st_e;

  typedef enum logic [1:0] {
    ERR_NONE = 2'd0, ERR_SIZE = 2'd1, ERR_PEER = 2'd2, ERR_TIME = 2'd3
  } err_e;
endpackage

// File: rtl/rx_hdr_dec.sv
module rx_hdr_dec
  import rx_reasm_pkg::*;
#(
  parameter int BUF_W = 12
) (
  input  logic [SLOT_W-1:0] word_i,
  input  logic [BUF_W-1:0]  left_i,
  output logic [HLEN_W-1:0] len_o,
  output logic [HLEN_W-2:0] words_o,
  output logic              cmpl_o,
  output logic              fits_o
);
  localparam int LW = (BUF_W > HLEN_W) ? BUF_W : HLEN_W;

  logic [HLEN_W:0] len_rnd;

  always_comb begin
    len_o   = word_i[HLEN_LSB +: HLEN_W];
    cmpl_o  = word_i[HDONE_BIT];
    len_rnd = {1'b0, len_o} + (HLEN_W+1)'(SLOT_B - 1);
    words_o = len_rnd[HLEN_W:2];
    fits_o  = LW'(len_o) <= LW'(left_i);
  end
endmodule

// File: rtl/rx_wait_timer.sv
module rx_wait_timer #(
  parameter int TO_W = 16
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            run_i,
  input  logic [TO_W-1:0] limit_i,
  output logic            expired_o
);
  logic [TO_W-1:0] cnt_q;

  assign expired_o = run_i && (cnt_q == limit_i);

  // counter clears whenever no wait is in progress
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                 cnt_q <= '0;
    else if (!run_i)             cnt_q <= '0;
    else if (!expired_o)         cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/rx_byte_sel.sv
module rx_byte_sel #(
  parameter int W  = 32,
  localparam int NB = W / 8,
  localparam int IW = (NB > 1) ? $clog2(NB) : 1
) (
  input  logic [W-1:0]  word_i,
  input  logic [IW-1:0] idx_i,
  output logic [7:0]    byte_o
);
  logic [7:0] lane [NB];

  for (genvar g = 0; g < NB; g++) begin : g_lane
    assign lane[g] = word_i[8*g +: 8];
  end

  assign byte_o = lane[idx_i];
endmodule

// File: rtl/rx_reasm.sv
module rx_reasm
  import rx_reasm_pkg::*;
#(
  parameter int BUF_W = 12,
  parameter int CNT_W = 8,
  parameter int TO_W  = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [BUF_W-1:0]  max_len_i,
  input  logic [TO_W-1:0]   timeout_i,
  input  logic [CNT_W-1:0]  fill_cnt_i,
  input  logic [31:0]       slot_data_i,
  input  logic              peer_rdy_i,
  output logic              slot_pop_o,
  output logic              irq_clr_o,
  output logic              irq_gen_o,
  output logic [7:0]        byte_data_o,
  output logic              byte_valid_o,
  input  logic              byte_ready_i,
  output logic              busy_o,
  output logic              done_o,
  output logic              ok_o,
  output logic [1:0]        err_o,
  output logic [BUF_W-1:0]  rx_len_o,
  output logic              zero_warn_o
);
  localparam int CW  = (CNT_W > HLEN_W-1) ? CNT_W : HLEN_W-1;
  localparam int BIW = $clog2(SLOT_B);

  st_e               st_q;
  err_e              err_q;
  logic [BUF_W-1:0]  left_q, total_q;
  logic [HLEN_W-1:0] rem_q;
  logic [HLEN_W-2:0] nwords_q;
  logic [BIW-1:0]    bidx_q;
  logic              cmpl_q, tail_q, ok_q, warn_q;

  logic [HLEN_W-1:0] h_len;
  logic [HLEN_W-2:0] h_words;
  logic              h_cmpl, h_fits;
  logic              fill_any, fill_ge, wait_run, expired, last_in_word, hs;

  rx_hdr_dec #(.BUF_W(BUF_W)) u_dec (
    .word_i (slot_data_i),
    .left_i (left_q),
    .len_o  (h_len),
    .words_o(h_words),
    .cmpl_o (h_cmpl),
    .fits_o (h_fits)
  );

  rx_wait_timer #(.TO_W(TO_W)) u_tmr (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .run_i    (wait_run),
    .limit_i  (timeout_i),
    .expired_o(expired)
  );

  rx_byte_sel #(.W(SLOT_W)) u_sel (
    .word_i(slot_data_i),
    .idx_i (bidx_q),
    .byte_o(byte_data_o)
  );

  always_comb begin
    fill_any     = fill_cnt_i != '0;
    fill_ge      = CW'(fill_cnt_i) >= CW'(nwords_q);
    wait_run     = (st_q == ST_HDR && !fill_any) || (st_q == ST_BODY && !fill_ge);
    last_in_word = (bidx_q == BIW'(SLOT_B - 1)) || (rem_q == HLEN_W'(1));
    hs           = (st_q == ST_STREAM) && byte_ready_i;
    byte_valid_o = st_q == ST_STREAM;
    slot_pop_o   = (st_q == ST_HDR && fill_any) || (hs && last_in_word);
    irq_clr_o    = st_q == ST_IDLE && start_i;
    irq_gen_o    = st_q == ST_NEXT && !cmpl_q && !fill_any;
    busy_o       = st_q != ST_IDLE;
    done_o       = st_q == ST_DONE;
    ok_o         = ok_q;
    err_o        = err_q;
    rx_len_o     = total_q;
    zero_warn_o  = warn_q;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q     <= ST_IDLE;
      err_q    <= ERR_NONE;
      left_q   <= '0;
      total_q  <= '0;
      rem_q    <= '0;
      nwords_q <= '0;
      bidx_q   <= '0;
      cmpl_q   <= 1'b0;
      tail_q   <= 1'b0;
      ok_q     <= 1'b0;
      warn_q   <= 1'b0;
    end else begin
      unique case (st_q)
        ST_IDLE: if (start_i) begin
          st_q    <= ST_HDR;
          left_q  <= max_len_i;
          total_q <= '0;
          err_q   <= ERR_NONE;
          ok_q    <= 1'b0;
          warn_q  <= 1'b0;
        end
        ST_HDR: begin
          if (fill_any) begin
            if (!h_fits) begin
              err_q <= ERR_SIZE;
              st_q  <= ST_DONE;
            end else begin
              rem_q    <= h_len;
              nwords_q <= h_words;
              cmpl_q   <= h_cmpl;
              left_q   <= left_q - BUF_W'(h_len);
              total_q  <= total_q + BUF_W'(h_len);
              if (h_len == '0) warn_q <= 1'b1;
              bidx_q   <= '0;
              tail_q   <= 1'b0;
              st_q     <= ST_BODY;
            end
          end else if (expired) begin
            err_q <= ERR_TIME;
            st_q  <= ST_DONE;
          end
        end
        ST_BODY: begin
          if (fill_ge) st_q <= (rem_q >= HLEN_W'(SLOT_B)) ? ST_STREAM : ST_CHECK;
          else if (expired) begin
            err_q <= ERR_TIME;
            st_q  <= ST_DONE;
          end
        end
        ST_STREAM: if (byte_ready_i) begin
          rem_q  <= rem_q - 1'b1;
          bidx_q <= bidx_q + 1'b1;
          if (last_in_word) begin
            bidx_q <= '0;
            if (tail_q)                            st_q <= ST_NEXT;
            else if (rem_q <= HLEN_W'(SLOT_B))     st_q <= ST_CHECK;
          end
        end
        ST_CHECK: begin
          if (!peer_rdy_i) begin
            err_q <= ERR_PEER;
            st_q  <= ST_DONE;
          end else if (rem_q != '0) begin
            tail_q <= 1'b1;
            st_q   <= ST_STREAM;
          end else st_q <= ST_NEXT;
        end
        ST_NEXT: begin
          if (cmpl_q) begin
            ok_q <= 1'b1;
            st_q <= ST_DONE;
          end else st_q <= ST_HDR;
        end
        ST_DONE: st_q <= ST_IDLE;
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  AST_NO_EMPTY_POP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    slot_pop_o |-> fill_cnt_i != '0); // R3
  AST_STREAM_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (byte_valid_o && !byte_ready_i && !slot_pop_o) |=> (byte_valid_o && $stable(byte_data_o))); // R11
  AST_DONE_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o); // R12
  AST_REQ_ONLY_EMPTY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_gen_o |-> fill_cnt_i == '0); // R6
  AST_OK_NO_ERR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && ok_o) |-> err_o == 2'd0); // R7
  AST_CLR_STARTS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_clr_o |=> (busy_o && !irq_clr_o)); // R9
endmodule

// File: tb/rx_reasm_test.sv
module rx_reasm_test;
  localparam int CLK_P = 10;
  localparam int BUF_W = 12;
  localparam int CNT_W = 8;
  localparam int TO_W  = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic [BUF_W-1:0] max_len = '0;
  logic [TO_W-1:0]  tmo = '0;
  logic [CNT_W-1:0] fill = '0;
  logic [31:0]      head = '0;
  logic peer = 1'b1;
  logic pop, iclr, igen, bvalid, busy, done, ok, warn;
  logic bready = 1'b1;
  logic [7:0] bdata;
  logic [1:0] err;
  logic [BUF_W-1:0] rlen;

  int errors = 0, checks = 0;
  logic [31:0] mbox[$];
  logic [7:0]  exp_b[$];
  logic pend_pop = 1'b0, pend_byte = 1'b0, done_seen = 1'b0, bp_en = 1'b0;
  logic [7:0] pend_data = '0, seed = 8'h10;
  logic [7:0] lfsr = 8'h5a;
  int irq_cnt = 0, clr_cnt = 0;
  logic r_ok = 1'b0, r_warn = 1'b0;
  logic [1:0] r_err = '0;
  logic [BUF_W-1:0] r_len = '0;

  always #(CLK_P/2) clk = ~clk;

  rx_reasm #(.BUF_W(BUF_W), .CNT_W(CNT_W), .TO_W(TO_W)) uut (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .max_len_i(max_len),
    .timeout_i(tmo), .fill_cnt_i(fill), .slot_data_i(head), .peer_rdy_i(peer),
    .slot_pop_o(pop), .irq_clr_o(iclr), .irq_gen_o(igen), .byte_data_o(bdata),
    .byte_valid_o(bvalid), .byte_ready_i(bready), .busy_o(busy), .done_o(done),
    .ok_o(ok), .err_o(err), .rx_len_o(rlen), .zero_warn_o(warn)
  );

  function automatic void refresh();
    fill = CNT_W'(mbox.size());
    head = (mbox.size() != 0) ? mbox[0] : 32'h0;
  endfunction

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Reference: queue words of one fragment, expect first emit bytes on the stream
  task automatic push_frag(input int len, input bit cmpl, input int emit);
    logic [31:0] w;
    mbox.push_back({cmpl, 6'h0, 9'(len), 16'h0201});
    w = '0;
    for (int k = 0; k < len; k++) begin
      w[8*(k%4) +: 8] = seed;
      if (k < emit) exp_b.push_back(seed);
      seed = seed + 8'd7;
      if (k % 4 == 3 || k == len - 1) begin
        mbox.push_back(w);
        w = '0;
      end
    end
    refresh();
  endtask

  // Monitor: effects of the previous edge first, then sample what the next edge commits
  always @(negedge clk) begin
    if (rst_n) begin
      if (pend_pop) begin
        chk("R3 pop from non-empty queue", int'(mbox.size() != 0), 1);
        if (mbox.size() != 0) void'(mbox.pop_front());
        refresh();
      end
      if (pend_byte) begin
        if (exp_b.size() == 0) chk("R4 unexpected byte", int'(pend_data), -1);
        else chk("R4 byte value", int'(pend_data), int'(exp_b.pop_front()));
      end
      lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
      bready = bp_en ? (lfsr[0] | lfsr[2]) : 1'b1;
      #1;
      pend_pop  = pop;
      pend_byte = bvalid && bready;
      pend_data = bdata;
      if (igen) irq_cnt++;
      if (iclr) clr_cnt++;
      if (done) begin
        done_seen = 1'b1;
        r_ok = ok; r_err = err; r_len = rlen; r_warn = warn;
      end
    end
  end

  task automatic kick(input int mx, input int to);
    @(posedge clk); #2;
    max_len = BUF_W'(mx); tmo = TO_W'(to);
    irq_cnt = 0; clr_cnt = 0; done_seen = 1'b0;
    start = 1'b1;
    @(posedge clk); #2;
    start = 1'b0;
  endtask

  task automatic wait_done();
    int n = 0;
    while (!done_seen && n < 5000) begin @(posedge clk); n++; end
    if (!done_seen) chk("watchdog: done never seen", 0, 1);
  endtask

  task automatic verify(input string req, input int e_ok, input int e_err, input int e_len,
                        input int e_warn, input int e_left, input int e_irq);
    chk({req, " ok"}, int'(r_ok), e_ok);
    chk({req, " err code"}, int'(r_err), e_err);
    if (e_ok == 1) chk({req, " R7 length"}, int'(r_len), e_len);
    chk({req, " R8 zero warn"}, int'(r_warn), e_warn);
    chk({req, " words left in queue"}, mbox.size(), e_left);
    chk({req, " R4 all bytes out"}, exp_b.size(), 0);
    chk({req, " R6 request pulses"}, irq_cnt, e_irq);
    chk({req, " R9 clear pulses"}, clr_cnt, 1);
    @(posedge clk); #2;
    chk({req, " R12 results hold"}, int'({ok, err, warn}), int'({r_ok, r_err, r_warn}));
    mbox.delete(); exp_b.delete(); refresh();
    peer = 1'b1; bp_en = 1'b0;
  endtask

  initial begin
    #(CLK_P * 150000);
    errors++;
    $display("FAIL watchdog: actual=running expected=finished");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #2;
    chk("reset busy", int'(busy), 0);
    chk("reset valid", int'(bvalid), 0);
    chk("reset pop", int'(pop), 0);
    chk("R12 reset done", int'(done), 0);
    rst_n = 1'b1;

    // R1 R4 R7 R11: single fragment, partial tail, random backpressure
    bp_en = 1'b1;
    push_frag(10, 1'b1, 10);
    kick(64, 200); wait_done();
    verify("R1 R4 R7 single", 1, 0, 10, 0, 0, 0);

    // R7: three fragments queued ahead, no request expected
    push_frag(8, 1'b0, 8); push_frag(3, 1'b0, 3); push_frag(4, 1'b1, 4);
    kick(64, 200); wait_done();
    verify("R7 three frags", 1, 0, 15, 0, 0, 0);

    // R6 R12: queue runs dry after non-final fragment; start while busy ignored
    push_frag(8, 1'b0, 8);
    kick(64, 1000);
    begin
      int n = 0;
      while (irq_cnt == 0 && n < 2000) begin @(posedge clk); n++; end
    end
    #2;
    start = 1'b1; @(posedge clk); #2; start = 1'b0;
    push_frag(5, 1'b1, 5);
    wait_done();
    verify("R6 R12 refill", 1, 0, 13, 0, 0, 1);

    // R8: zero-length final fragment
    push_frag(0, 1'b1, 0);
    kick(64, 200); wait_done();
    verify("R8 zero len", 1, 0, 0, 1, 0, 0);

    // R2: one byte too large, then exactly fitting
    push_frag(17, 1'b1, 0);
    kick(16, 200); wait_done();
    verify("R2 too large", 0, 1, 0, 0, 5, 0);
    push_frag(16, 1'b1, 16);
    kick(16, 200); wait_done();
    verify("R2 exact fit", 1, 0, 16, 0, 0, 0);

    // R2: space used up by earlier fragment
    push_frag(8, 1'b0, 8); push_frag(10, 1'b1, 0);
    kick(16, 200); wait_done();
    verify("R2 space used", 0, 1, 0, 0, 3, 0);

    // R5: sender not ready, tail word remains
    peer = 1'b0;
    push_frag(6, 1'b1, 4);
    kick(64, 200); wait_done();
    verify("R5 peer lost", 0, 2, 0, 0, 1, 0);

    // R10: payload never completes
    push_frag(8, 1'b1, 0);
    void'(mbox.pop_back()); refresh();
    kick(64, 15); wait_done();
    verify("R10 timeout", 0, 3, 0, 0, 1, 0);

    // R10: header never arrives
    kick(64, 15); wait_done();
    verify("R10 no header", 0, 3, 0, 0, 0, 0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule